// File: doc/BRIEF.md
# Two-Bank Clock Divider with Odd-Ratio 50% Duty

This block divides a fast source clock by 2, 4 or 5 and drives two output banks from one shared counter. A 3-bit ratio code selects the divisor for both banks together. Each bank has its own enable. The output duty cycle is 50% for every ratio. For the odd ratio, the falling output edge comes from a copy of the count-decoded waveform that is delayed by half a source cycle on the falling clock edge.

The ratio code and the bank enables are sampled only in the last source cycle of an output period. A change therefore never shortens or stretches a pulse: it takes effect on the rising edge that opens the next period. A code outside the three legal values selects divide-by-4 and sets a sticky error flag. A synchronous master reset holds both outputs low and clears the flag. The first rising clock edge after reset is released opens a fresh period.

Top module: `clkdiv_bank`

## Requirements
- R1: Ratio code 3'b001 divides by 2. An enabled output is high for one source cycle and then low for one source cycle.
- R2: Ratio code 3'b011 divides by 4. An enabled output is high for two source cycles and then low for two.
- R3: Ratio code 3'b100 divides by 5. An enabled output rises on a rising source edge, falls on the falling source edge 2.5 cycles later, and stays low for 2.5 cycles.
- R4: Any other ratio code divides by 4. The code_err flag goes high at the period boundary that loads such a code, and it stays high until reset, whatever codes follow.
- R5: Both banks use the same ratio and the same phase. When both are enabled, out_a equals out_b at all times.
- R6: A new ratio code that is applied in the middle of a period has no effect on that period. The new ratio starts with the next period.
- R7: Each bank's enable is sampled at the period boundary. A disabled bank stays low for whole periods. A re-enabled bank resumes with a rising edge at the start of a period.
- R8: While mrst is high, both outputs are low and code_err is 0. The first rising clock edge that samples mrst low starts a period, and each enabled output rises at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock; both edges are used |
| mrst | input | 1 | Master reset, active high, synchronous |
| ratio_code | input | 3 | Divisor select: 001 is /2, 011 is /4, 100 is /5, any other value is /4 with an error |
| en_a | input | 1 | Bank A enable, sampled at the period boundary |
| en_b | input | 1 | Bank B enable, sampled at the period boundary |
| out_a | output | 1 | Bank A divided clock |
| out_b | output | 1 | Bank B divided clock |
| code_err | output | 1 | Sticky flag for an illegal ratio code |

## Verification
Each output is sampled twice per source cycle, at a quarter and at three quarters of the cycle. The expected waveform is rebuilt one half-cycle slot at a time, so an error of half a cycle in the odd-ratio falling edge is caught, and so is a swap between the /4 and /5 patterns. Each of the eight code values is started from reset, which separates the three legal ratios from the fallback and checks the sticky flag for every illegal code. Mid-period changes to the code and to each enable, in both directions between /2 and /5, show whether the design samples these inputs only at the boundary or lets them cut the current pulse.

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank (
  input  logic       clk,
  input  logic       mrst,
  input  logic [2:0] ratio_code,
  input  logic       en_a,
  input  logic       en_b,
  output logic       out_a,
  output logic       out_b,
  output logic       code_err
);
  typedef enum logic [1:0] {DIV2 = 2'd0, DIV4 = 2'd1, DIV5 = 2'd2} ratio_e;

  ratio_e     div, nxt_div;
  logic [2:0] cnt, last, half;
  logic       ena_q, enb_q, base, dly, odd, wrap, code_ok;

  always_comb begin
    case (ratio_code)
      3'b001:  nxt_div = DIV2;
      3'b100:  nxt_div = DIV5;
      default: nxt_div = DIV4;
    endcase
  end

  assign code_ok = (ratio_code == 3'b001) || (ratio_code == 3'b011) || (ratio_code == 3'b100);
  assign last    = (div == DIV2) ? 3'd1 : (div == DIV5) ? 3'd4 : 3'd3;
  assign half    = (div == DIV2) ? 3'd1 : 3'd2;
  assign wrap    = (cnt == last);
  assign base    = (cnt < half);
  assign odd     = (div == DIV5);

  // reset parks the count on the last slot so release opens a period
  always_ff @(posedge clk) begin
    if (mrst) begin
      div      <= DIV4;
      cnt      <= 3'd3;
      ena_q    <= 1'b0;
      enb_q    <= 1'b0;
      code_err <= 1'b0;
    end else if (wrap) begin
      cnt   <= 3'd0;
      div   <= nxt_div;
      ena_q <= en_a;
      enb_q <= en_b;
      if (!code_ok) code_err <= 1'b1;
    end else begin
      cnt <= cnt + 3'd1;
    end
  end

  always_ff @(negedge clk) begin
    dly <= mrst ? 1'b0 : base;
  end

  assign out_a = ena_q & (base | (odd & dly));
  assign out_b = enb_q & (base | (odd & dly));
endmodule

module clkdiv_bank_chk (
  input logic       clk,
  input logic       mrst,
  input logic [2:0] ratio_code,
  input logic       out_a,
  input logic       out_b,
  input logic       code_err,
  input logic [2:0] cnt,
  input logic [2:0] last,
  input logic [1:0] div,
  input logic       ena_q,
  input logic       enb_q
);
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (mrst)
    $past(mrst) |-> (!out_a && !out_b && !code_err));

  p_ratio_hold_r6: assert property (@(posedge clk) disable iff (mrst)
    (cnt != last) |=> $stable(div));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (mrst)
    code_err |=> code_err);

  p_bad_code_r4: assert property (@(posedge clk) disable iff (mrst)
    ((cnt == last) && !(ratio_code inside {3'b001, 3'b011, 3'b100})) |=> code_err);

  p_banks_match_r5: assert property (@(posedge clk) disable iff (mrst)
    (ena_q && enb_q) |-> (out_a == out_b));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (mrst)
    cnt <= last);
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
  .clk(clk), .mrst(mrst), .ratio_code(ratio_code), .out_a(out_a), .out_b(out_b),
  .code_err(code_err), .cnt(cnt), .last(last), .div(div), .ena_q(ena_q), .enb_q(enb_q)
);

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic [2:0] code = 3'b011;
  logic       en_a = 1'b1;
  logic       en_b = 1'b1;
  logic       out_a, out_b, code_err;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  clkdiv_bank uut (
    .clk(clk), .mrst(mrst), .ratio_code(code), .en_a(en_a), .en_b(en_b),
    .out_a(out_a), .out_b(out_b), .code_err(code_err)
  );

  always #10 clk = ~clk;

  // {code, divisor, expected error flag}
  localparam logic [6:0] VEC [8] = '{
    {3'b001, 3'd2, 1'b0}, {3'b011, 3'd4, 1'b0}, {3'b100, 3'd5, 1'b0},
    {3'b000, 3'd4, 1'b1}, {3'b010, 3'd4, 1'b1}, {3'b101, 3'd4, 1'b1},
    {3'b110, 3'd4, 1'b1}, {3'b111, 3'd4, 1'b1}
  };

  task automatic chk_slot(input int n, input int s, input bit ea, input bit eb, input string req);
    bit h;
    h = (s < n);
    total++;
    if (out_a !== (ea & h) || out_b !== (eb & h)) begin
      bad++;
      $display("FAIL %s: /%0d slot %0d a=%b b=%b expected a=%b b=%b",
               req, n, s, out_a, out_b, ea & h, eb & h);
    end
  endtask

  task automatic chk_err(input bit exp, input string req);
    total++;
    if (code_err !== exp) begin
      bad++;
      $display("FAIL %s: code_err=%b expected %b", req, code_err, exp);
    end
  endtask

  // entered just after a period-opening edge; leaves just after the next one
  task automatic period(input int n, input bit ea, input bit eb,
                        input logic [2:0] nc, input bit nea, input bit neb, input string req);
    for (int c = 0; c < n; c++) begin
      #5;
      chk_slot(n, 2*c, ea, eb, req);
      if (c == 0) begin code = nc; en_a = nea; en_b = neb; end
      #10;
      chk_slot(n, 2*c+1, ea, eb, req);
      @(posedge clk);
    end
  endtask

  task automatic start(input logic [2:0] c, input bit ea, input bit eb);
    #2 mrst = 1'b1; code = c; en_a = ea; en_b = eb;
    @(posedge clk);
    #5;  chk_slot(1, 1, 1'b0, 1'b0, "R8 reset low");
    chk_err(1'b0, "R8 reset clears flag");
    #10; chk_slot(1, 1, 1'b0, 1'b0, "R8 reset low");
    @(posedge clk);
    #2 mrst = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] vc;
      int         vn;
      bit         ve;
      string      rq;
      vc = VEC[i][6:4]; vn = int'(VEC[i][3:1]); ve = VEC[i][0];
      rq = (vn == 2) ? "R1" : (vn == 5) ? "R3" : ve ? "R4" : "R2";
      start(vc, 1'b1, 1'b1);
      period(vn, 1'b1, 1'b1, vc, 1'b1, 1'b1, rq);
      period(vn, 1'b1, 1'b1, vc, 1'b1, 1'b1, "R5");
      chk_err(ve, "R4 flag per code");
    end

    // R6: ratio change mid-period waits for the boundary
    start(3'b001, 1'b1, 1'b1);
    period(2, 1'b1, 1'b1, 3'b100, 1'b1, 1'b1, "R6 old /2");
    period(5, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, "R6 new /5");
    period(2, 1'b1, 1'b1, 3'b011, 1'b1, 1'b1, "R6 back /2");
    period(4, 1'b1, 1'b1, 3'b011, 1'b1, 1'b1, "R6 /4");

    // R7: per-bank enables at period boundaries
    start(3'b011, 1'b1, 1'b1);
    period(4, 1'b1, 1'b1, 3'b011, 1'b0, 1'b1, "R7 a still on");
    period(4, 1'b0, 1'b1, 3'b011, 1'b0, 1'b1, "R7 a off");
    period(4, 1'b0, 1'b1, 3'b100, 1'b1, 1'b0, "R7 a off");
    period(5, 1'b1, 1'b0, 3'b100, 1'b1, 1'b1, "R7 a back b off");
    period(5, 1'b1, 1'b1, 3'b100, 1'b1, 1'b1, "R7 b back");

    // R4: sticky flag survives legal codes, cleared by reset
    start(3'b011, 1'b1, 1'b1);
    period(4, 1'b1, 1'b1, 3'b110, 1'b1, 1'b1, "R4 before");
    chk_err(1'b0, "R4 not yet");
    period(4, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, "R4 fallback");
    chk_err(1'b1, "R4 set");
    period(2, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, "R4 legal after");
    chk_err(1'b1, "R4 sticky");
    start(3'b001, 1'b1, 1'b1);
    period(2, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, "R8 restart");
    chk_err(1'b0, "R8 flag cleared");

    // R8: reset from the middle of a /5 period
    start(3'b100, 1'b1, 1'b1);
    period(5, 1'b1, 1'b1, 3'b100, 1'b1, 1'b1, "R8 /5");
    #7;
    start(3'b100, 1'b1, 1'b1);
    period(5, 1'b1, 1'b1, 3'b100, 1'b1, 1'b1, "R8 after mid reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule